// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control and status registers on a simple request/response bus. Each request carries a valid strobe, a write flag, a word index (byte offset divided by four) and write data. One cycle later the block returns a response strobe, the read data and an access-error flag. Software must unlock the bank before it can change ordinary control registers. Unlocking takes a fixed 16-bit key written to a dedicated unlock register. A different key written to a dedicated lock register closes the bank again.

Each mapped register has a legality class: read/write, read-only or write-only. A write to a read-only or unmapped word is dropped and flagged. A read of a write-only or unmapped word is flagged and returns zero. A write to the reset-control register with bit 0 set, made while the bank is unlocked, produces a one-cycle system soft-reset request. The boot-mode register reports a 4-bit strap value. This value is taken on the first clock after reset is released.

Word map: 0x000 single-bit scratch (always writable), 0x001 lock (write-only), 0x002 unlock (write-only), 0x003 lock status (read-only), 0x040 to 0x042 PLL controls, 0x043 PLL status (read-only), 0x048 to 0x04F general controls, 0x080 reset control, 0x097 boot mode (read-only). All other words are unmapped.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the lock-status word (0x003) reads 1, each PLL control reads 0x0001A008, PLL status (0x043) reads 0x0000003F, every other read/write register reads 0, and no response or soft-reset request is pending.
- R2: A write to word 0x001 whose data bits [15:0] equal 0x767B sets the lock-status flag. Any other value, and the upper 16 bits, have no effect on the flag.
- R3: A write to word 0x002 whose data bits [15:0] equal 0xDF0D clears the lock-status flag. A wrong key leaves the flag unchanged.
- R4: While the flag is 1, writes to read/write registers other than word 0x000 are discarded and are not flagged as errors.
- R5: Word 0x000 accepts writes whether or not the bank is locked. It stores only data bit 0, and bits [31:1] always read as 0.
- R6: A write to a read-only word (0x003, 0x043, 0x097) or an unmapped word changes no state and returns error 1.
- R7: A read of a write-only word (0x001, 0x002) or an unmapped word returns error 1 and data 0. Legal accesses return error 0.
- R8: A write to word 0x080 with data bit 0 set, made while unlocked, drives soft_rst_req_o high for exactly the response cycle. A write while locked, or one with bit 0 clear, gives no request.
- R9: Word 0x097 reads the 4-bit strap sampled on the first clock after reset is released, zero-extended. Later strap changes have no effect.
- R10: While unlocked, every read/write register other than word 0x000 stores all 32 data bits and reads them back.
- R11: rsp_valid_o is high exactly in the cycle after each request and low otherwise. rsp_err_o and rsp_rdata_o are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 10 | Word index of the register |
| req_wdata_i | input | 32 | Write data |
| boot_strap_i | input | 4 | Boot-mode strap pins |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rsp_rdata_o | output | 32 | Read data (0 for writes and illegal reads) |
| rsp_err_o | output | 1 | Access-error flag for the response |
| soft_rst_req_o | output | 1 | One-cycle system soft-reset request |

## Verification
The bench sweeps the whole 1024-word space with reads after reset, again after a locked write sweep, and again after an unlocked write sweep. A reference model tracks the expected contents, lock flag and error class of every word. A design that decoded a word into the wrong class would show up in the sweep. It would either flag a legal access or let a read-only or unmapped write land in storage. A design that ignored the lock would have its registers altered by the locked sweep. Directed cases cover off-by-one keys and keys with junk in the upper half. They also check the scratch bit being written while locked, a reset-control write while locked or with bit 0 clear, and a later strap change. A block that compared all 32 key bits, stored full words at 0x000, or pulsed the reset request for longer than one cycle fails these cases.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DATA_W = 32;
  localparam int WORD_W = 10;
  localparam int KEY_W  = 16;
  localparam int BOOT_W = 4;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t W_SCRATCH = 10'h000;
  localparam word_t W_LOCK    = 10'h001;
  localparam word_t W_UNLOCK  = 10'h002;
  localparam word_t W_LSTAT   = 10'h003;
  localparam word_t W_PLL     = 10'h040;
  localparam word_t W_PSTAT   = 10'h043;
  localparam word_t W_CTRL    = 10'h048;
  localparam word_t W_RSTCTL  = 10'h080;
  localparam word_t W_BOOT    = 10'h097;

  localparam logic [KEY_W-1:0]  LOCK_KEY     = 16'h767B;
  localparam logic [KEY_W-1:0]  UNLOCK_KEY   = 16'hDF0D;
  localparam logic [DATA_W-1:0] PLL_RST_VAL  = 32'h0001_A008;
  localparam logic [DATA_W-1:0] PSTAT_VAL    = 32'h0000_003F;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SCRATCH, SEL_LOCK, SEL_UNLOCK, SEL_LSTAT,
    SEL_PLL, SEL_PSTAT, SEL_CTRL, SEL_RSTCTL, SEL_BOOT
  } sel_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int NUM_PLL  = 3,
  parameter int NUM_CTRL = 8,
  parameter int IDX_W    = 3
) (
  input  word_t            word_i,
  output sel_e             sel_o,
  output acc_e             acc_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam word_t PLL_END  = W_PLL + WORD_W'(NUM_PLL);
  localparam word_t CTRL_END = W_CTRL + WORD_W'(NUM_CTRL);

  always_comb begin
    sel_o = SEL_NONE;
    acc_o = ACC_NONE;
    idx_o = '0;
    if (word_i == W_SCRATCH) begin
      sel_o = SEL_SCRATCH; acc_o = ACC_RW;
    end else if (word_i == W_LOCK) begin
      sel_o = SEL_LOCK;    acc_o = ACC_WO;
    end else if (word_i == W_UNLOCK) begin
      sel_o = SEL_UNLOCK;  acc_o = ACC_WO;
    end else if (word_i == W_LSTAT) begin
      sel_o = SEL_LSTAT;   acc_o = ACC_RO;
    end else if (word_i == W_PSTAT) begin
      sel_o = SEL_PSTAT;   acc_o = ACC_RO;
    end else if (word_i == W_RSTCTL) begin
      sel_o = SEL_RSTCTL;  acc_o = ACC_RW;
    end else if (word_i == W_BOOT) begin
      sel_o = SEL_BOOT;    acc_o = ACC_RO;
    end else if (word_i >= W_PLL && word_i < PLL_END) begin
      sel_o = SEL_PLL;     acc_o = ACC_RW;
      idx_o = IDX_W'(word_i - W_PLL);
    end else if (word_i >= W_CTRL && word_i < CTRL_END) begin
      sel_o = SEL_CTRL;    acc_o = ACC_RW;
      idx_o = IDX_W'(word_i - W_CTRL);
    end
  end
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_wr_i,
  input  logic             unlock_wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 locked_q <= 1'b1;
    else if (lock_wr_i && key_i == LOCK_KEY)     locked_q <= 1'b1;
    else if (unlock_wr_i && key_i == UNLOCK_KEY) locked_q <= 1'b0;
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int NUM_PLL  = 3,
  parameter int NUM_CTRL = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_we_i,
  input  logic              scratch_we_i,
  input  sel_e              sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              locked_i,
  input  logic [BOOT_W-1:0] boot_strap_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] pll_q  [NUM_PLL];
  logic [DATA_W-1:0] ctrl_q [NUM_CTRL];
  logic [DATA_W-1:0] rstctl_q;
  logic              scratch_q;
  logic [BOOT_W-1:0] boot_q;
  logic              cap_q;

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pll_q[g] <= PLL_RST_VAL;
      else if (store_we_i && sel_i == SEL_PLL && idx_i == IDX_W'(g)) pll_q[g] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q[g] <= '0;
      else if (store_we_i && sel_i == SEL_CTRL && idx_i == IDX_W'(g)) ctrl_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rstctl_q  <= '0;
      scratch_q <= 1'b0;
    end else begin
      if (store_we_i && sel_i == SEL_RSTCTL) rstctl_q <= wdata_i;
      if (scratch_we_i) scratch_q <= wdata_i[0];
    end
  end

  // strap taken on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= 1'b1;
      boot_q <= '0;
    end else if (cap_q) begin
      cap_q  <= 1'b0;
      boot_q <= boot_strap_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_SCRATCH: rdata_o = {{(DATA_W-1){1'b0}}, scratch_q};
      SEL_LSTAT:   rdata_o = {{(DATA_W-1){1'b0}}, locked_i};
      SEL_PSTAT:   rdata_o = PSTAT_VAL;
      SEL_RSTCTL:  rdata_o = rstctl_q;
      SEL_BOOT:    rdata_o = {{(DATA_W-BOOT_W){1'b0}}, boot_q};
      SEL_PLL: begin
        for (int i = 0; i < NUM_PLL; i++)
          if (idx_i == IDX_W'(i)) rdata_o = pll_q[i];
      end
      SEL_CTRL: begin
        for (int i = 0; i < NUM_CTRL; i++)
          if (idx_i == IDX_W'(i)) rdata_o = ctrl_q[i];
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int NUM_PLL  = 3,
  parameter int NUM_CTRL = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [WORD_W-1:0] req_word_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BOOT_W-1:0] boot_strap_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              soft_rst_req_o
);
  localparam int MAX_N = (NUM_PLL > NUM_CTRL) ? NUM_PLL : NUM_CTRL;
  localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  sel_e              sel;
  acc_e              acc;
  logic [IDX_W-1:0]  idx;
  logic              locked;
  logic [DATA_W-1:0] rf_rdata;

  logic wr, rd, wr_ok, rd_ok, store_we, scratch_we, srst_d;

  sysctl_decode #(.NUM_PLL(NUM_PLL), .NUM_CTRL(NUM_CTRL), .IDX_W(IDX_W)) u_decode (
    .word_i (req_word_i),
    .sel_o  (sel),
    .acc_o  (acc),
    .idx_o  (idx)
  );

  assign wr    = req_valid_i && req_write_i;
  assign rd    = req_valid_i && !req_write_i;
  assign wr_ok = (acc == ACC_RW) || (acc == ACC_WO);
  assign rd_ok = (acc == ACC_RW) || (acc == ACC_RO);

  assign scratch_we = wr && sel == SEL_SCRATCH;
  assign store_we   = wr && acc == ACC_RW && sel != SEL_SCRATCH && !locked;
  assign srst_d     = store_we && sel == SEL_RSTCTL && req_wdata_i[0];

  sysctl_lock u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_wr_i   (wr && sel == SEL_LOCK),
    .unlock_wr_i (wr && sel == SEL_UNLOCK),
    .key_i       (req_wdata_i[KEY_W-1:0]),
    .locked_o    (locked)
  );

  sysctl_regfile #(.NUM_PLL(NUM_PLL), .NUM_CTRL(NUM_CTRL), .IDX_W(IDX_W)) u_regfile (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .store_we_i   (store_we),
    .scratch_we_i (scratch_we),
    .sel_i        (sel),
    .idx_i        (idx),
    .wdata_i      (req_wdata_i),
    .locked_i     (locked),
    .boot_strap_i (boot_strap_i),
    .rdata_o      (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_rdata_o    <= '0;
      rsp_err_o      <= 1'b0;
      soft_rst_req_o <= 1'b0;
    end else begin
      rsp_valid_o    <= req_valid_i;
      rsp_rdata_o    <= (rd && rd_ok) ? rf_rdata : '0;
      rsp_err_o      <= (wr && !wr_ok) || (rd && !rd_ok);
      soft_rst_req_o <= srst_d;
    end
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk
  import sysctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [WORD_W-1:0] req_word_i,
  input logic [KEY_W-1:0]  wkey_i,
  input logic              wbit0_i,
  input logic              locked_i,
  input logic              rsp_valid_i,
  input logic [DATA_W-1:1] rdata_hi_i,
  input logic              rsp_err_i,
  input logic              soft_rst_i
);
  logic wr, rd;
  assign wr = req_valid_i && req_write_i;
  assign rd = req_valid_i && !req_write_i;

  assert_rsp_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_i);
  assert_no_rsp_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_i);
  assert_lock_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_word_i == W_LOCK && wkey_i == LOCK_KEY) |=> locked_i);
  assert_unlock_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_word_i == W_UNLOCK && wkey_i == UNLOCK_KEY) |=> !locked_i);
  // lock flag moves only on key-register writes (R2, R3)
  assert_lock_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (req_word_i == W_LOCK || req_word_i == W_UNLOCK)) |=> $stable(locked_i));
  assert_srst_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |-> $past(wr && req_word_i == W_RSTCTL && wbit0_i && !locked_i));
  assert_ro_write_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && (req_word_i == W_PSTAT || req_word_i == W_LSTAT || req_word_i == W_BOOT)) |=> rsp_err_i);
  assert_wo_read_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (req_word_i == W_LOCK || req_word_i == W_UNLOCK)) |=> (rsp_err_i && rdata_hi_i == '0));
  assert_scratch_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && req_word_i == W_SCRATCH) |=> (!rsp_err_i && rdata_hi_i == '0));
endmodule

bind sysctl_regbank sysctl_regbank_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_word_i  (req_word_i),
  .wkey_i      (req_wdata_i[sysctl_pkg::KEY_W-1:0]),
  .wbit0_i     (req_wdata_i[0]),
  .locked_i    (locked),
  .rsp_valid_i (rsp_valid_o),
  .rdata_hi_i  (rsp_rdata_o[sysctl_pkg::DATA_W-1:1]),
  .rsp_err_i   (rsp_err_o),
  .soft_rst_i  (soft_rst_req_o)
);

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i, req_write_i;
  logic [9:0]  req_word_i;
  logic [31:0] req_wdata_i;
  logic [3:0]  boot_strap_i;
  logic        rsp_valid_o, rsp_err_o, soft_rst_req_o;
  logic [31:0] rsp_rdata_o;

  sysctl_regbank i_sysctl_regbank (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_word_i, .req_wdata_i,
    .boot_strap_i, .rsp_valid_o, .rsp_rdata_o, .rsp_err_o, .soft_rst_req_o
  );

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] mdl [1024];
  bit          m_locked;
  logic [3:0]  m_boot;

  // 0 unmapped, 1 read/write, 2 read-only, 3 write-only
  function automatic int cls(int w);
    if (w == 0) return 1;
    if (w == 1 || w == 2) return 3;
    if (w == 3 || w == 'h43 || w == 'h97) return 2;
    if (w >= 'h40 && w <= 'h42) return 1;
    if (w >= 'h48 && w <= 'h4F) return 1;
    if (w == 'h80) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd(int w);
    if (w == 3)    return {31'b0, m_locked};
    if (w == 'h43) return 32'h0000_003F;
    if (w == 'h97) return {28'b0, m_boot};
    if (cls(w) == 1) return mdl[w];
    return 32'h0;
  endfunction

  function automatic string tag_of(int w, string dflt);
    if (w == 0)    return "R5";
    if (w == 'h97) return "R9";
    return dflt;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(bit wr, int w, logic [31:0] d);
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_word_i  = 10'(w);
    req_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
  endtask

  task automatic do_rd(int w, string tag);
    logic [31:0] e;
    bit ee;
    string t;
    e  = exp_rd(w);
    ee = (cls(w) == 0) || (cls(w) == 3);
    t  = ee ? "R7" : tag_of(w, tag);
    acc(1'b0, w, 32'h0);
    chk(rsp_valid_o == 1'b1, "R11", {31'b0, rsp_valid_o}, 32'h1);
    chk(rsp_rdata_o == e, t, rsp_rdata_o, e);
    chk(rsp_err_o == ee, t, {31'b0, rsp_err_o}, {31'b0, ee});
  endtask

  task automatic do_wr(int w, logic [31:0] d, string tag);
    int c;
    bit ee, es;
    c  = cls(w);
    ee = (c == 0) || (c == 2);
    es = (w == 'h80) && !m_locked && d[0];
    acc(1'b1, w, d);
    chk(rsp_valid_o == 1'b1, "R11", {31'b0, rsp_valid_o}, 32'h1);
    chk(rsp_err_o == ee, ee ? "R6" : tag, {31'b0, rsp_err_o}, {31'b0, ee});
    chk(soft_rst_req_o == es, "R8", {31'b0, soft_rst_req_o}, {31'b0, es});
    if (w == 0) mdl[0] = {31'b0, d[0]};
    else if (c == 1 && !m_locked) mdl[w] = d;
    if (w == 1 && d[15:0] == 16'h767B) m_locked = 1'b1;
    if (w == 2 && d[15:0] == 16'hDF0D) m_locked = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    req_valid_i = 1'b0;
    req_write_i = 1'b0;
    req_word_i  = '0;
    req_wdata_i = '0;
    boot_strap_i = 4'hA;
    m_boot = 4'hA;
    m_locked = 1'b1;
    for (int i = 0; i < 1024; i++) mdl[i] = 32'h0;
    for (int i = 'h40; i <= 'h42; i++) mdl[i] = 32'h0001_A008;

    repeat (3) @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R1", {31'b0, rsp_valid_o}, 32'h0);
    chk(soft_rst_req_o == 1'b0, "R1", {31'b0, soft_rst_req_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R11", {31'b0, rsp_valid_o}, 32'h0);
    boot_strap_i = 4'h5;  // must not be picked up (R9)

    for (int w = 0; w < 1024; w++) do_rd(w, "R1");

    // key handling
    do_wr(2, 32'h0000_DF0E, "R3"); do_rd(3, "R3");
    do_wr(2, 32'h1234_DF0D, "R3"); do_rd(3, "R3");
    do_wr(1, 32'h0000_767C, "R2"); do_rd(3, "R2");
    do_wr(1, 32'hFFFF_767B, "R2"); do_rd(3, "R2");

    // locked: scratch still writable, reset control not
    do_wr(0, 32'hFFFF_FFFE, "R5"); do_rd(0, "R5");
    do_wr(0, 32'h8000_0001, "R5"); do_rd(0, "R5");
    do_wr('h80, 32'h0000_0001, "R8"); do_rd('h80, "R4");

    for (int w = 0; w < 1024; w++) do_wr(w, {16'h1111, 16'(w) ^ 16'h5A5B}, "R4");
    for (int w = 0; w < 1024; w++) do_rd(w, "R4");

    do_wr(2, 32'h0000_DF0D, "R3"); do_rd(3, "R3");
    for (int w = 0; w < 1024; w++) do_wr(w, {16'h2222, 16'(w) ^ 16'h3C3C}, "R10");
    for (int w = 0; w < 1024; w++) do_rd(w, "R10");

    // soft-reset request
    do_wr('h80, 32'h0000_0003, "R8");
    @(posedge clk_i);
    @(negedge clk_i);
    chk(soft_rst_req_o == 1'b0, "R8", {31'b0, soft_rst_req_o}, 32'h0);
    chk(rsp_valid_o == 1'b0, "R11", {31'b0, rsp_valid_o}, 32'h0);
    do_wr('h80, 32'hFFFF_FFFE, "R8");
    do_rd('h80, "R10");
    do_rd('h97, "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule